// File: doc/BRIEF.md
# Delayed Window DMA Engine

This block copies 32-bit words between a 4 KiB on-chip buffer and external memory. Software sets up a source address, a destination address, a byte count and a command word through a small register port. One side of every transfer is the buffer, which appears in the block's local address space as a fixed window. The other side is external memory, reached through a word-wide request port with a valid/ready handshake. In that port a read returns its data in the same beat that the request is accepted.

A command write with the run bit set locks the four parameter registers. The engine then waits a fixed number of cycles before it moves any data. When the wait ends, it checks that the local range lies wholly inside the window. If the check fails, the engine sets a sticky error flag and moves nothing. If it passes, the engine moves one word per accepted beat. At the end it clears the run bit and, when asked to, pulses an interrupt request. External addresses are masked to a configurable number of low bits before they leave the block.

Top module: `dma_window_engine`

## Requirements
- R1: The registers are 64 bits wide at these offsets: source 0x80, destination 0x88, byte count 0x90, command 0x98. Only access sizes 4 and 8 are honoured. A size-8 write stores all 64 bits. A size-4 write stores the low 32 data bits, zero-extended. A size-4 read returns the low 32 bits, zero-extended. A write of any other size is ignored. A read of any other size, or of an unmapped offset, returns all ones. After reset all four registers read 0.
- R2: Command bit 0 is run. Bit 1 is direction: 0 copies external memory into the buffer, 1 copies the buffer to external memory. Bit 2 asks for an interrupt on completion. A command write with bit 0 clear changes nothing.
- R3: While the run bit is 1, writes to all four registers are ignored, and reads still return their contents.
- R4: No request is issued before START_DELAY clock edges have passed since the edge that accepted the run write. The first request is presented right after that many edges.
- R5: With direction 0, beat i reads external address (source + 4i) masked. The word returned is stored in buffer word (destination − 0x40000)/4 + i.
- R6: With direction 1, beat i writes buffer word (source − 0x40000)/4 + i to external address (destination + 4i) masked.
- R7: Every external address presented is ANDed with a mask that keeps its low MASK_BITS bits (28 by default).
- R8: Take the low 32 bits of the local-side register as the start, and let end = start + count, computed modulo 2^32. The transfer goes ahead only if all of these hold:
  - start lies in [0x40000, 0x41000);
  - end > start;
  - end lies in [0x40000, 0x41000);
  - start and count are both multiples of 4.
  Otherwise no request is made, the run bit clears, the error flag sets and no interrupt is raised.
- R9: After the last accepted beat the run bit reads 0. The interrupt output is high for exactly one cycle if command bit 2 was set, and stays low otherwise.
- R10: The error flag stays set until the next run command is accepted, which clears it.
- R11: While a request is held off by ready low, valid, direction and address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset for reads and writes |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational from offset and size) |
| mem_req_valid | output | 1 | External request valid |
| mem_req_ready | input | 1 | External request accepted |
| mem_req_write | output | 1 | 1 = write to external memory, 0 = read |
| mem_req_addr | output | EXT_AW | Masked external byte address |
| mem_req_wdata | output | 32 | Write data from the buffer |
| mem_rdata | input | 32 | Read data, valid in the accepting beat |
| dma_irq | output | 1 | One-cycle completion interrupt request |
| dma_err | output | 1 | Sticky range-error flag |

## Verification
The bench builds the engine with a START_DELAY of 16, so the exact cycle of the first request can be checked on every run without long waits. It keeps the full 4 KiB buffer, so both edges of the window can be hit: a 4092-byte transfer is legal, while a range ending exactly at 0x41000 is not. The external side is 40 bits wide with the default 28-bit mask, so random source and destination values with high bits set show the masking on every beat. Ready is driven randomly, which exercises back-pressure throughout.

// File: rtl/dma_win_pkg.sv
package dma_win_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MOVE = 2'd2
    } dma_state_e;

    localparam logic [7:0] OFS_SRC = 8'h80;
    localparam logic [7:0] OFS_DST = 8'h88;
    localparam logic [7:0] OFS_CNT = 8'h90;
    localparam logic [7:0] OFS_CMD = 8'h98;

    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 1;
    localparam int CMD_IRQ = 2;

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] dst;
        logic [63:0] cnt;
        logic [63:0] cmd;
    } dma_regs_t;

endpackage

// File: rtl/dma_win_regs.sv
module dma_win_regs
    import dma_win_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [3:0]        size_i,
    input  logic [63:0]       wdata_i,
    output logic [63:0]       rdata_o,
    input  logic              clear_run_i,
    output dma_regs_t         regs_o,
    output logic              start_o
);

    dma_regs_t   regs_d, regs_q;
    logic        size_ok;
    logic [63:0] wval;
    logic [63:0] rsel;
    logic        hit;

    assign size_ok = (size_i == 4'd4) || (size_i == 4'd8);
    assign wval    = (size_i == 4'd8) ? wdata_i : {32'h0, wdata_i[31:0]};

    always_comb begin
        regs_d  = regs_q;
        start_o = 1'b0;
        if (wr_en_i && size_ok && !regs_q.cmd[CMD_RUN]) begin
            case (addr_i)
                REG_AW'(OFS_SRC): regs_d.src = wval;
                REG_AW'(OFS_DST): regs_d.dst = wval;
                REG_AW'(OFS_CNT): regs_d.cnt = wval;
                REG_AW'(OFS_CMD): begin
                    if (wval[CMD_RUN]) begin
                        regs_d.cmd = wval;
                        start_o    = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (clear_run_i) begin
            regs_d.cmd[CMD_RUN] = 1'b0;
        end
    end

    always_comb begin
        hit  = 1'b1;
        rsel = '1;
        case (addr_i)
            REG_AW'(OFS_SRC): rsel = regs_q.src;
            REG_AW'(OFS_DST): rsel = regs_q.dst;
            REG_AW'(OFS_CNT): rsel = regs_q.cnt;
            REG_AW'(OFS_CMD): rsel = regs_q.cmd;
            default:          hit  = 1'b0;
        endcase
        if (!hit || !size_ok) begin
            rdata_o = '1;
        end else if (size_i == 4'd4) begin
            rdata_o = {32'h0, rsel[31:0]};
        end else begin
            rdata_o = rsel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/dma_win_buf.sv
module dma_win_buf #(
    parameter int WORDS = 1024,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [IDX_W-1:0] raddr_i,
    output logic [DW-1:0]    rdata_o
);

    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/dma_win_ctrl.sv
module dma_win_ctrl
    import dma_win_pkg::*;
#(
    parameter int          BUF_WORDS   = 1024,
    parameter logic [31:0] WIN_BASE    = 32'h0004_0000,
    parameter int          START_DELAY = 100,
    parameter int          EXT_AW      = 40,
    parameter int          MASK_BITS   = 28,
    localparam int         IDX_W       = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  dma_regs_t         regs_i,
    output logic              clear_run_o,
    output logic              mem_valid_o,
    input  logic              mem_ready_i,
    output logic              mem_write_o,
    output logic [EXT_AW-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    output logic              buf_we_o,
    output logic [IDX_W-1:0]  buf_idx_o,
    output logic [31:0]       buf_wdata_o,
    input  logic [31:0]       buf_rdata_i,
    output logic              irq_o,
    output logic              err_o
);

    localparam int          DLY_W     = $clog2(START_DELAY + 1);
    localparam logic [31:0] WIN_END   = WIN_BASE + 32'(BUF_WORDS * 4);
    localparam logic [EXT_AW-1:0] ADDR_MASK = ~({EXT_AW{1'b1}} << MASK_BITS);

    typedef struct packed {
        dma_state_e        state;
        logic [DLY_W-1:0]  dly;
        logic [IDX_W-1:0]  beat;
        logic [IDX_W-1:0]  last;
        logic [IDX_W-1:0]  lbase;
        logic [EXT_AW-1:0] xbase;
        logic              dir;
        logic              irq_en;
        logic              irq;
        logic              err;
    } ctrl_t;

    ctrl_t       st_d, st_q;
    logic [31:0] loc_start;
    logic [31:0] byte_cnt;
    logic [31:0] loc_end;
    logic [31:0] loc_off;
    logic        range_ok;
    logic        clr_now;
    logic [IDX_W-1:0] lidx;
    logic [EXT_AW-1:0] xraw;
    logic        unused_bits;

    // Local-side range check, evaluated while the registers are locked
    always_comb begin
        loc_start = regs_i.cmd[CMD_DIR] ? regs_i.src[31:0] : regs_i.dst[31:0];
        byte_cnt  = regs_i.cnt[31:0];
        loc_end   = loc_start + byte_cnt;
        loc_off   = loc_start - WIN_BASE;
        range_ok  = (loc_start >= WIN_BASE) && (loc_start < WIN_END) &&
                    (loc_end > loc_start) &&
                    (loc_end >= WIN_BASE) && (loc_end < WIN_END) &&
                    (loc_start[1:0] == 2'b00) && (byte_cnt[1:0] == 2'b00);
    end

    always_comb begin
        st_d    = st_q;
        st_d.irq = 1'b0;
        clr_now = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.state = ST_WAIT;
                    st_d.dly   = DLY_W'(START_DELAY - 1);
                    st_d.err   = 1'b0;
                end
            end
            ST_WAIT: begin
                if (st_q.dly == '0) begin
                    if (range_ok) begin
                        st_d.state  = ST_MOVE;
                        st_d.beat   = '0;
                        st_d.last   = byte_cnt[IDX_W+1:2] - IDX_W'(1);
                        st_d.lbase  = loc_off[IDX_W+1:2];
                        st_d.xbase  = regs_i.cmd[CMD_DIR] ? regs_i.dst[EXT_AW-1:0]
                                                          : regs_i.src[EXT_AW-1:0];
                        st_d.dir    = regs_i.cmd[CMD_DIR];
                        st_d.irq_en = regs_i.cmd[CMD_IRQ];
                    end else begin
                        st_d.state = ST_IDLE;
                        st_d.err   = 1'b1;
                        clr_now    = 1'b1;
                    end
                end else begin
                    st_d.dly = st_q.dly - DLY_W'(1);
                end
            end
            ST_MOVE: begin
                if (mem_ready_i) begin
                    if (st_q.beat == st_q.last) begin
                        st_d.state = ST_IDLE;
                        st_d.irq   = st_q.irq_en;
                        clr_now    = 1'b1;
                    end else begin
                        st_d.beat = st_q.beat + IDX_W'(1);
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lidx = st_q.lbase + st_q.beat;
    assign xraw = st_q.xbase + EXT_AW'({st_q.beat, 2'b00});

    assign clear_run_o = clr_now;
    assign mem_valid_o = (st_q.state == ST_MOVE);
    assign mem_write_o = st_q.dir;
    assign mem_addr_o  = xraw & ADDR_MASK;
    assign mem_wdata_o = buf_rdata_i;
    assign buf_we_o    = (st_q.state == ST_MOVE) && !st_q.dir && mem_ready_i;
    assign buf_idx_o   = lidx;
    assign buf_wdata_o = mem_rdata_i;
    assign irq_o       = st_q.irq;
    assign err_o       = st_q.err;

    assign unused_bits = ^{regs_i.src[63:EXT_AW], regs_i.dst[63:EXT_AW],
                           regs_i.cnt[63:32], regs_i.cmd[63:3], regs_i.cmd[CMD_RUN],
                           loc_off[31:IDX_W+2], loc_off[1:0],
                           byte_cnt[31:IDX_W+2], byte_cnt[1:0]};

endmodule

// File: rtl/dma_window_engine.sv
module dma_window_engine
    import dma_win_pkg::*;
#(
    parameter int          BUF_BYTES   = 4096,
    parameter logic [31:0] WIN_BASE    = 32'h0004_0000,
    parameter int          START_DELAY = 100,
    parameter int          EXT_AW      = 40,
    parameter int          MASK_BITS   = 28,
    parameter int          REG_AW      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [3:0]        reg_size,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [EXT_AW-1:0] mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              dma_irq,
    output logic              dma_err
);

    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int IDX_W     = $clog2(BUF_WORDS);

    dma_regs_t        regs;
    logic             start_w;
    logic             clear_run;
    logic             buf_we;
    logic [IDX_W-1:0] buf_idx;
    logic [31:0]      buf_wdata;
    logic [31:0]      buf_rdata;

    dma_win_regs #(
        .REG_AW (REG_AW)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (reg_wr_en),
        .addr_i      (reg_addr),
        .size_i      (reg_size),
        .wdata_i     (reg_wdata),
        .rdata_o     (reg_rdata),
        .clear_run_i (clear_run),
        .regs_o      (regs),
        .start_o     (start_w)
    );

    dma_win_ctrl #(
        .BUF_WORDS   (BUF_WORDS),
        .WIN_BASE    (WIN_BASE),
        .START_DELAY (START_DELAY),
        .EXT_AW      (EXT_AW),
        .MASK_BITS   (MASK_BITS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_w),
        .regs_i      (regs),
        .clear_run_o (clear_run),
        .mem_valid_o (mem_req_valid),
        .mem_ready_i (mem_req_ready),
        .mem_write_o (mem_req_write),
        .mem_addr_o  (mem_req_addr),
        .mem_wdata_o (mem_req_wdata),
        .mem_rdata_i (mem_rdata),
        .buf_we_o    (buf_we),
        .buf_idx_o   (buf_idx),
        .buf_wdata_o (buf_wdata),
        .buf_rdata_i (buf_rdata),
        .irq_o       (dma_irq),
        .err_o       (dma_err)
    );

    dma_win_buf #(
        .WORDS (BUF_WORDS),
        .DW    (32)
    ) u_buf (
        .clk     (clk),
        .we_i    (buf_we),
        .waddr_i (buf_idx),
        .wdata_i (buf_wdata),
        .raddr_i (buf_idx),
        .rdata_o (buf_rdata)
    );

endmodule

// File: rtl/dma_window_engine_chk.sv
module dma_window_engine_chk #(
    parameter int START_DELAY = 100,
    parameter int EXT_AW      = 40,
    parameter int MASK_BITS   = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [EXT_AW-1:0] mem_req_addr,
    input logic              dma_irq,
    input logic              dma_err,
    input logic              run,
    input logic              start,
    input logic [63:0]       src,
    input logic [63:0]       dst,
    input logic [63:0]       cnt
);

    localparam int SW = $clog2(START_DELAY + 1);
    localparam logic [EXT_AW-1:0] HIGH_BITS = {EXT_AW{1'b1}} << MASK_BITS;

    logic [SW-1:0] since_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_start <= '0;
        end else if (start) begin
            since_start <= '0;
        end else if (since_start != SW'(START_DELAY)) begin
            since_start <= since_start + SW'(1);
        end
    end

    assert_locked_regs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(src) && $stable(dst) && $stable(cnt)));

    assert_start_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (run && since_start == SW'(START_DELAY)));

    assert_addr_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ((mem_req_addr & HIGH_BITS) == '0));

    assert_err_clears_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_err) |-> (!run && !mem_req_valid && !dma_irq));

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |-> (!run && !mem_req_valid) ##1 !dma_irq);

    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

endmodule

bind dma_window_engine dma_window_engine_chk #(
    .START_DELAY (START_DELAY),
    .EXT_AW      (EXT_AW),
    .MASK_BITS   (MASK_BITS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .dma_irq       (dma_irq),
    .dma_err       (dma_err),
    .run           (regs.cmd[0]),
    .start         (start_w),
    .src           (regs.src),
    .dst           (regs.dst),
    .cnt           (regs.cnt)
);

// File: tb/dma_window_engine_test.sv
module dma_window_engine_test;

    localparam int          DLY  = 16;
    localparam int          EAW  = 40;
    localparam int          MB   = 28;
    localparam logic [31:0] BASE = 32'h0004_0000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n;
    logic           reg_wr_en;
    logic [7:0]     reg_addr;
    logic [3:0]     reg_size;
    logic [63:0]    reg_wdata;
    logic [63:0]    reg_rdata;
    logic           mem_req_valid;
    logic           mem_req_ready;
    logic           mem_req_write;
    logic [EAW-1:0] mem_req_addr;
    logic [31:0]    mem_req_wdata;
    logic [31:0]    mem_rdata;
    logic           dma_irq;
    logic           dma_err;

    int          checks = 0;
    int          fails  = 0;
    logic [31:0] salt   = 32'h1;
    logic [31:0] model [1024];

    dma_window_engine #(
        .START_DELAY (DLY),
        .EXT_AW      (EAW),
        .MASK_BITS   (MB)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_size      (reg_size),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rdata     (mem_rdata),
        .dma_irq       (dma_irq),
        .dma_err       (dma_err)
    );

    function automatic logic [31:0] ext_word(logic [EAW-1:0] a, logic [31:0] s);
        return (a[31:0] * 32'h9E37_79B1) ^ s;
    endfunction

    function automatic logic [EAW-1:0] emask(logic [63:0] a);
        return a[EAW-1:0] & ~({EAW{1'b1}} << MB);
    endfunction

    assign mem_rdata = ext_word(mem_req_addr, salt);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [3:0] sz, input logic [63:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, input logic [3:0] sz, output logic [63:0] v);
        reg_wr_en = 1'b0; reg_addr = a; reg_size = sz;
        #1;
        v = reg_rdata;
        @(negedge clk);
    endtask

    task automatic setup(input logic [63:0] s, input logic [63:0] d, input logic [63:0] c);
        reg_write(8'h80, 4'd8, s);
        reg_write(8'h88, 4'd8, d);
        reg_write(8'h90, 4'd8, c);
    endtask

    // Watches one transfer; call at the negedge right after the run write edge.
    task automatic monitor(input bit dir, input logic [63:0] xbase, input int lword,
                           input int nwords, input bit irq_en, input bit chk_delay);
        int  seen  = 0;
        int  first = -1;
        int  bad   = 0;
        bit  done  = 0;
        logic [63:0] v;
        for (int k = 1; k < DLY + nwords * 6 + 40 && !done; k++) begin
            mem_req_ready = ($urandom % 4) != 0;
            if (mem_req_valid) begin
                if (first < 0) begin
                    first = k;
                    if (chk_delay) chk("R4 first request cycle", 64'(k), 64'(DLY + 1));
                end
                if (mem_req_addr !== emask(xbase + 64'(4 * seen))) begin
                    bad++;
                    $display("FAIL R5/R6/R7 beat %0d addr: got %h expected %h",
                             seen, mem_req_addr, emask(xbase + 64'(4 * seen)));
                end
                if (mem_req_write !== dir) begin
                    bad++;
                    $display("FAIL R2 direction: got %b expected %b", mem_req_write, dir);
                end
                if (dir && mem_req_wdata !== model[lword + seen]) begin
                    bad++;
                    $display("FAIL R6 beat %0d data: got %h expected %h",
                             seen, mem_req_wdata, model[lword + seen]);
                end
                if (mem_req_ready) begin
                    if (!dir) model[lword + seen] = mem_rdata;
                    seen++;
                    if (seen == nwords) done = 1;
                end
            end
            @(negedge clk);
        end
        mem_req_ready = 1'b0;
        checks++;
        if (bad != 0) fails++;
        chk("R5/R6 beats accepted", 64'(seen), 64'(nwords));
        chk("R9 irq pulse", {63'h0, dma_irq}, {63'h0, irq_en});
        @(negedge clk);
        chk("R9 irq one cycle", {63'h0, dma_irq}, 64'h0);
        chk("R9 no extra request", {63'h0, mem_req_valid}, 64'h0);
        reg_read(8'h98, 4'd8, v);
        chk("R9 run cleared", {63'h0, v[0]}, 64'h0);
    endtask

    task automatic xfer(input bit dir, input logic [63:0] s, input logic [63:0] d,
                        input int bytes, input bit irq_en);
        int lw;
        setup(s, d, 64'(bytes));
        lw = dir ? int'((s[31:0] - BASE) >> 2) : int'((d[31:0] - BASE) >> 2);
        reg_write(8'h98, 4'd8, {61'h0, irq_en, dir, 1'b1});
        monitor(dir, dir ? d : s, lw, bytes / 4, irq_en, 1'b1);
    endtask

    task automatic bad_range(input string tag, input bit dir, input logic [31:0] loc,
                             input logic [31:0] bytes);
        bit          saw_req = 0;
        bit          saw_irq = 0;
        logic [63:0] v;
        if (dir) setup({32'h0, loc}, 64'h100, {32'h0, bytes});
        else     setup(64'h100, {32'h0, loc}, {32'h0, bytes});
        reg_write(8'h98, 4'd8, {61'h0, 1'b1, dir, 1'b1});
        mem_req_ready = 1'b1;
        for (int k = 0; k < DLY + 6; k++) begin
            if (mem_req_valid) saw_req = 1;
            if (dma_irq) saw_irq = 1;
            @(negedge clk);
        end
        mem_req_ready = 1'b0;
        chk({"R8 no request ", tag}, {63'h0, saw_req}, 64'h0);
        chk({"R8 no irq ", tag}, {63'h0, saw_irq}, 64'h0);
        chk({"R8 err flag ", tag}, {63'h0, dma_err}, 64'h1);
        reg_read(8'h98, 4'd8, v);
        chk({"R8 run cleared ", tag}, {63'h0, v[0]}, 64'h0);
    endtask

    initial begin
        logic [63:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) model[i] = 32'h0;
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = 8'h0; reg_size = 4'd8;
        reg_wdata = 64'h0; mem_req_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        reg_read(8'h80, 4'd8, v); chk("R1 reset src", v, 64'h0);
        reg_read(8'h98, 4'd8, v); chk("R1 reset cmd", v, 64'h0);
        chk("R1 reset valid", {63'h0, mem_req_valid}, 64'h0);
        chk("R9 reset irq", {63'h0, dma_irq}, 64'h0);
        chk("R8 reset err", {63'h0, dma_err}, 64'h0);

        // R1 access sizes
        reg_write(8'h80, 4'd8, 64'h1122_3344_5566_7788);
        reg_read(8'h80, 4'd8, v); chk("R1 size-8 read", v, 64'h1122_3344_5566_7788);
        reg_read(8'h80, 4'd4, v); chk("R1 size-4 read", v, 64'h0000_0000_5566_7788);
        reg_write(8'h88, 4'd4, 64'hAAAA_BBBB_CCCC_DDDD);
        reg_read(8'h88, 4'd8, v); chk("R1 size-4 write", v, 64'h0000_0000_CCCC_DDDD);
        reg_write(8'h90, 4'd2, 64'h1234);
        reg_read(8'h90, 4'd8, v); chk("R1 size-2 write ignored", v, 64'h0);
        reg_read(8'h80, 4'd1, v); chk("R1 size-1 read", v, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_read(8'h40, 4'd8, v); chk("R1 unmapped read", v, 64'hFFFF_FFFF_FFFF_FFFF);

        // R2 command without run is ignored
        reg_write(8'h98, 4'd8, 64'h6);
        repeat (DLY + 3) @(negedge clk);
        chk("R2 no run no request", {63'h0, mem_req_valid}, 64'h0);
        reg_read(8'h98, 4'd8, v); chk("R2 cmd unchanged", v, 64'h0);

        // R5 R7 load with high external bits set and interrupt
        salt = 32'h5A5A_0001;
        xfer(1'b0, 64'h0000_00FF_F123_4500, {32'h0, BASE}, 64, 1'b1);

        // R3 lock during the wait, then R6 store
        setup({32'h0, BASE + 32'h8}, 64'h0000_0012_3456_7800, 64'd16);
        reg_write(8'h98, 4'd8, 64'h3);
        reg_write(8'h80, 4'd8, 64'hDEAD_BEEF);
        reg_write(8'h90, 4'd8, 64'h4);
        reg_read(8'h80, 4'd8, v); chk("R3 src locked", v, {32'h0, BASE + 32'h8});
        reg_read(8'h90, 4'd8, v); chk("R3 cnt locked", v, 64'd16);
        monitor(1'b1, 64'h0000_0012_3456_7800, 2, 4, 1'b0, 1'b0);

        // Largest legal load fills words 0..1022
        salt = 32'hC0DE_0002;
        xfer(1'b0, 64'h0000_0000_0800_0000, {32'h0, BASE}, 4092, 1'b0);
        xfer(1'b1, {32'h0, BASE + 32'd4088}, 64'h1000, 4, 1'b1);

        // R8 range errors, R10 sticky flag
        bad_range("below window", 1'b0, BASE - 32'd4, 32'd8);
        bad_range("end at window top", 1'b0, BASE + 32'd4088, 32'd8);
        bad_range("zero count", 1'b1, BASE, 32'd0);
        bad_range("unaligned start", 1'b0, BASE + 32'd2, 32'd8);
        bad_range("unaligned count", 1'b1, BASE + 32'd16, 32'd6);
        bad_range("wrapping end", 1'b0, BASE + 32'd16, 32'hFFFF_FFF8);
        repeat (10) @(negedge clk);
        chk("R10 err sticky", {63'h0, dma_err}, 64'h1);
        setup(64'h40, {32'h0, BASE + 32'h40}, 64'd8);
        reg_write(8'h98, 4'd8, 64'h1);
        chk("R10 err cleared by start", {63'h0, dma_err}, 64'h0);
        monitor(1'b0, 64'h40, 16, 2, 1'b0, 1'b1);

        // Random transfers
        for (int it = 0; it < 24; it++) begin
            int          off   = int'($urandom % 1000) * 4;
            int          maxw  = (4092 - off) / 4;
            int          nw    = 1 + int'($urandom % ((maxw < 32) ? maxw : 32));
            bit          dir   = $urandom % 2;
            bit          irqe  = $urandom % 2;
            logic [63:0] xa    = {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_FFFC;
            salt = $urandom;
            if (dir) xfer(1'b1, {32'h0, BASE + 32'(off)}, xa, nw * 4, irqe);
            else     xfer(1'b0, xa, {32'h0, BASE + 32'(off)}, nw * 4, irqe);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule